// File: doc/BRIEF.md
# Extended-Carry Integer ALU

This block is a 32-bit integer execution unit for a processor pipeline. Each accepted operation takes two operands, an opcode, a size code and the current condition flag word. It returns a registered result together with a writeback enable. Add, subtract, negate and compare can chain a carry across words, which makes multiword arithmetic possible. That chaining is gated by an extension flag, so ordinary arithmetic ignores a stale carry.

Shifts use the whole 32-bit shift amount and saturate when it exceeds the datapath width. Multiplies build the full double-width product. The low half returns as the normal result, and the high half is written to a separate special register through its own enable. Multiplies take two cycles and raise `busy` while they are in flight. Every other operation completes one cycle after acceptance.

Top module: `xalu_core`

## Requirements
- R1: The flag word carries C at bit 0, X at bit 4 and R at bit 8. ADD (opcode 0) returns a+b, plus 1 only when X and C are both set.
- R2: ADDC (opcode 1) returns a+b+C whatever the value of X. ADDR (opcode 2) returns a+b+R.
- R3: SUB (opcode 3) and CMP (opcode 5) compute a-b, minus 1 only when X and C are both set. NEG (opcode 4) computes 0-b minus the same gated carry.
- R4: CMP computes its result but returns it with out_wb low. Reserved opcodes 14 and 15 return 0 with out_wb low. Every other opcode asserts out_wb with its result.
- R5: LSL (opcode 7) and LSR (opcode 8) shift a by b, where b is read as an unsigned 32-bit amount. Any amount above 31 gives 0.
- R6: ASR (opcode 9) shifts a arithmetically. An amount above 31 gives all ones when a is negative and 0 otherwise.
- R7: BOUND (opcode 10) returns b when a > b unsigned, and otherwise returns a.
- R8: MOVE (opcode 6) returns b. ABS (opcode 11) returns -b when b is negative as a signed value, and otherwise returns b.
- R9: MULS (opcode 12, signed) and MULU (opcode 13, unsigned) form the 64-bit product. The low word goes to out_result and the high word goes to out_hi, with out_hi_we high for that one cycle. When out_hi_we is low, out_hi is 0.
- R10: Size code 0 masks the result to 8 bits and size code 1 masks it to 16 bits. Codes 2 and 3 keep all 32 bits. The mask applies to the low result of every opcode, including multiply, but never to out_hi.
- R11: A non-multiply operation accepted at an edge has out_valid high after that edge. A multiply raises busy for one cycle and presents its result one cycle later. in_valid is ignored while busy is high.
- R12: While rst is high at an edge, out_valid, out_wb, out_hi_we and busy go low, and out_result and out_hi go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_op | input | 4 | Opcode |
| in_size | input | 2 | Result size code |
| in_flags | input | 16 | Current flag word |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B / shift amount |
| busy | output | 1 | Multiply in flight, requests ignored |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Result (low product word for multiply) |
| out_wb | output | 1 | Result should be written back |
| out_hi | output | 32 | High product word |
| out_hi_we | output | 1 | Write enable for the high product register |

## Verification
A wrong carry gate or a wrong flag bit position shows as an off-by-one result on the very next valid cycle, but only for flag words where X and C differ. For that reason the vectors pair X-only, C-only and X-plus-C cases. A stuck multiply-pending state would show as busy staying high, or as a second result appearing one cycle after a multiply. That result would come from an ignored request. Both are visible within two cycles of the multiply's acceptance. Shift saturation faults appear only at amounts of 32 and above, so amounts of 31, 32 and 0x80000000 are driven explicitly.

// File: rtl/xalu_pkg.sv
`timescale 1ns/1ps
package xalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_ADDR  = 4'd2,
        OP_SUB   = 4'd3,
        OP_NEG   = 4'd4,
        OP_CMP   = 4'd5,
        OP_MOVE  = 4'd6,
        OP_LSL   = 4'd7,
        OP_LSR   = 4'd8,
        OP_ASR   = 4'd9,
        OP_BOUND = 4'd10,
        OP_ABS   = 4'd11,
        OP_MULS  = 4'd12,
        OP_MULU  = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_ALT   = 2'd3
    } size_e;

    // Flag word bit positions (behaviour depends on them).
    localparam int FLG_C = 0;
    localparam int FLG_X = 4;
    localparam int FLG_R = 8;

    typedef struct packed {
        logic c;
        logic x;
        logic r;
    } cflags_t;

    function automatic logic is_mul(input op_e op);
        return (op == OP_MULS) || (op == OP_MULU);
    endfunction

    function automatic logic is_defined(input logic [3:0] code);
        return code <= 4'd13;
    endfunction

endpackage

// File: rtl/xalu_arith.sv
`timescale 1ns/1ps
module xalu_arith
    import xalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  cflags_t       fl,
    output logic [DW-1:0] y
);
    logic          chain;
    logic [DW-1:0] cin;

    assign chain = fl.x & fl.c;

    always_comb begin
        cin = '0;
        y   = '0;
        unique case (op)
            OP_ADD: begin
                cin[0] = chain;
                y = a + b + cin;
            end
            OP_ADDC: begin
                cin[0] = fl.c;
                y = a + b + cin;
            end
            OP_ADDR: begin
                cin[0] = fl.r;
                y = a + b + cin;
            end
            OP_SUB, OP_CMP: begin
                cin[0] = chain;
                y = a - b - cin;
            end
            OP_NEG: begin
                cin[0] = chain;
                y = '0 - b - cin;
            end
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/xalu_shift.sv
`timescale 1ns/1ps
module xalu_shift
    import xalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    localparam int AW = $clog2(DW);

    logic          over;
    logic [AW-1:0] amt;

    assign over = |b[DW-1:AW];
    assign amt  = b[AW-1:0];

    always_comb begin
        unique case (op)
            OP_LSL:  y = over ? '0 : (a << amt);
            OP_LSR:  y = over ? '0 : (a >> amt);
            OP_ASR:  y = over ? {DW{a[DW-1]}} : DW'($signed(a) >>> amt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/xalu_mult.sv
`timescale 1ns/1ps
module xalu_mult #(
    parameter int DW = 32
) (
    input  logic            sgn,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] p
);
    logic [2*DW-1:0] ea;
    logic [2*DW-1:0] eb;

    assign ea = {{DW{sgn & a[DW-1]}}, a};
    assign eb = {{DW{sgn & b[DW-1]}}, b};
    // Truncated double-width product is correct for both signednesses.
    assign p  = ea * eb;
endmodule

// File: rtl/xalu_core.sv
`timescale 1ns/1ps
module xalu_core
    import xalu_pkg::*;
#(
    parameter int DW = 32,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic [1:0]    in_size,
    input  logic [FW-1:0] in_flags,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic          busy,
    output logic          out_valid,
    output logic [DW-1:0] out_result,
    output logic          out_wb,
    output logic [DW-1:0] out_hi,
    output logic          out_hi_we
);
    localparam int PW = 2 * DW;

    op_e           op;
    size_e         sz;
    cflags_t       fl;
    logic          accept;
    logic          unused_flags;

    logic [DW-1:0] arith_y;
    logic [DW-1:0] shift_y;
    logic [DW-1:0] sel_y;
    logic          sel_wb;

    logic          mul_pend;
    logic          m_sgn;
    size_e         m_size;
    logic [DW-1:0] m_a;
    logic [DW-1:0] m_b;
    logic [PW-1:0] prod;

    assign op           = op_e'(in_op);
    assign sz           = size_e'(in_size);
    assign fl           = '{c: in_flags[FLG_C], x: in_flags[FLG_X], r: in_flags[FLG_R]};
    assign unused_flags = ^in_flags;
    assign accept       = in_valid & ~mul_pend;
    assign busy         = mul_pend;

    function automatic logic [DW-1:0] fit(input size_e s, input logic [DW-1:0] v);
        logic [DW-1:0] m;
        unique case (s)
            SZ_BYTE: m = {{(DW-8){1'b0}}, 8'hFF};
            SZ_WORD: m = {{(DW-16){1'b0}}, 16'hFFFF};
            default: m = '1;
        endcase
        return v & m;
    endfunction

    xalu_arith #(.DW(DW)) u_arith (
        .op (op),
        .a  (in_a),
        .b  (in_b),
        .fl (fl),
        .y  (arith_y)
    );

    xalu_shift #(.DW(DW)) u_shift (
        .op (op),
        .a  (in_a),
        .b  (in_b),
        .y  (shift_y)
    );

    xalu_mult #(.DW(DW)) u_mult (
        .sgn (m_sgn),
        .a   (m_a),
        .b   (m_b),
        .p   (prod)
    );

    // Single-cycle result selection.
    always_comb begin
        sel_wb = is_defined(in_op) && (op != OP_CMP);
        unique case (op)
            OP_ADD, OP_ADDC, OP_ADDR,
            OP_SUB, OP_NEG, OP_CMP:  sel_y = arith_y;
            OP_MOVE:                 sel_y = in_b;
            OP_LSL, OP_LSR, OP_ASR:  sel_y = shift_y;
            OP_BOUND:                sel_y = (in_a > in_b) ? in_b : in_a;
            OP_ABS:                  sel_y = in_b[DW-1] ? (~in_b + 1'b1) : in_b;
            default:                 sel_y = '0;
        endcase
    end

    // Multiply operand stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            mul_pend <= 1'b0;
            m_sgn    <= 1'b0;
            m_size   <= SZ_DWORD;
            m_a      <= '0;
            m_b      <= '0;
        end else if (mul_pend) begin
            mul_pend <= 1'b0;
        end else if (accept && is_mul(op)) begin
            mul_pend <= 1'b1;
            m_sgn    <= (op == OP_MULS);
            m_size   <= sz;
            m_a      <= in_a;
            m_b      <= in_b;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_wb     <= 1'b0;
            out_hi     <= '0;
            out_hi_we  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_wb    <= 1'b0;
            out_hi    <= '0;
            out_hi_we <= 1'b0;
            if (mul_pend) begin
                out_valid  <= 1'b1;
                out_wb     <= 1'b1;
                out_result <= fit(m_size, prod[DW-1:0]);
                out_hi     <= prod[PW-1:DW];
                out_hi_we  <= 1'b1;
            end else if (accept && !is_mul(op)) begin
                out_valid  <= 1'b1;
                out_wb     <= sel_wb;
                out_result <= fit(sz, sel_y);
            end
        end
    end
endmodule

// File: rtl/xalu_core_chk.sv
`timescale 1ns/1ps
module xalu_core_chk
    import xalu_pkg::*;
#(
    parameter int DW = 32,
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [3:0]    in_op,
    input logic [1:0]    in_size,
    input logic [FW-1:0] in_flags,
    input logic [DW-1:0] in_a,
    input logic [DW-1:0] in_b,
    input logic          busy,
    input logic          out_valid,
    input logic [DW-1:0] out_result,
    input logic          out_wb,
    input logic [DW-1:0] out_hi,
    input logic          out_hi_we
);
    logic acc;
    logic mulreq;

    assign acc    = in_valid && !busy;
    assign mulreq = (in_op == OP_MULS) || (in_op == OP_MULU);

    AST_ADD_NO_CHAIN: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_ADD && !in_flags[FLG_X] && in_size[1]
        |=> out_result == $past(in_a) + $past(in_b)); // R1

    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_CMP |=> out_valid && !out_wb); // R4

    AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_wb |-> out_valid); // R4

    AST_LSL_SATURATE: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_LSL && in_b > 32'd31 |=> out_result == '0); // R5

    AST_HI_WE_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_hi_we |-> out_valid && out_wb); // R9

    AST_HI_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_hi_we |-> out_hi == '0); // R9

    AST_BYTE_MASK: assert property (@(posedge clk) disable iff (rst)
        acc && in_size == SZ_BYTE && !mulreq |=> out_result[DW-1:8] == '0); // R10

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc && !mulreq |=> out_valid && !busy); // R11

    AST_MUL_BUSY: assert property (@(posedge clk) disable iff (rst)
        acc && mulreq |=> busy && !out_valid); // R11

    AST_MUL_DONE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy && out_valid && out_hi_we); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !busy |=> !out_valid); // R11
endmodule

bind xalu_core xalu_core_chk #(.DW(DW), .FW(FW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_flags   (in_flags),
    .in_a       (in_a),
    .in_b       (in_b),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_wb     (out_wb),
    .out_hi     (out_hi),
    .out_hi_we  (out_hi_we)
);

// File: tb/xalu_core_test.sv
`timescale 1ns/1ps
module xalu_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [15:0] in_flags = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        busy;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_wb;
    logic [31:0] out_hi;
    logic        out_hi_we;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xalu_core uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_flags(in_flags), .in_a(in_a), .in_b(in_b),
        .busy(busy), .out_valid(out_valid), .out_result(out_result),
        .out_wb(out_wb), .out_hi(out_hi), .out_hi_we(out_hi_we)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [15:0] fl;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        wb;
        logic [31:0] hi;
    } vec_t;

    localparam int NV = 32;
    // Flag word: C=0x0001, X=0x0010, R=0x0100. Sizes: 0 byte, 1 word, 2 dword.
    localparam vec_t TBL [NV] = '{
        '{4'd0,  2'd2, 16'h0011, 32'h5,        32'h7,        32'hD,        1'b1, 32'h0},        // R1 X&C
        '{4'd0,  2'd2, 16'h0001, 32'h5,        32'h7,        32'hC,        1'b1, 32'h0},        // R1 C only
        '{4'd0,  2'd2, 16'h0010, 32'hFFFFFFFF, 32'h1,        32'h0,        1'b1, 32'h0},        // R1 X only
        '{4'd1,  2'd2, 16'h0001, 32'hA,        32'h14,       32'h1F,       1'b1, 32'h0},        // R2
        '{4'd2,  2'd2, 16'h0100, 32'hA,        32'h14,       32'h1F,       1'b1, 32'h0},        // R2
        '{4'd2,  2'd2, 16'h0011, 32'hA,        32'h14,       32'h1E,       1'b1, 32'h0},        // R2
        '{4'd3,  2'd2, 16'h0011, 32'hA,        32'h3,        32'h6,        1'b1, 32'h0},        // R3
        '{4'd3,  2'd2, 16'h0000, 32'h3,        32'hA,        32'hFFFFFFF9, 1'b1, 32'h0},        // R3
        '{4'd4,  2'd2, 16'h0011, 32'h0,        32'h1,        32'hFFFFFFFE, 1'b1, 32'h0},        // R3
        '{4'd5,  2'd2, 16'h0000, 32'h9,        32'h4,        32'h5,        1'b0, 32'h0},        // R4
        '{4'd6,  2'd0, 16'h0000, 32'h0,        32'h12345678, 32'h78,       1'b1, 32'h0},        // R8 R10
        '{4'd6,  2'd1, 16'h0000, 32'h0,        32'h12345678, 32'h5678,     1'b1, 32'h0},        // R8 R10
        '{4'd7,  2'd2, 16'h0000, 32'h1,        32'd31,       32'h80000000, 1'b1, 32'h0},        // R5
        '{4'd7,  2'd2, 16'h0000, 32'h1,        32'd32,       32'h0,        1'b1, 32'h0},        // R5
        '{4'd8,  2'd2, 16'h0000, 32'h80000000, 32'd31,       32'h1,        1'b1, 32'h0},        // R5
        '{4'd8,  2'd2, 16'h0000, 32'hFFFFFFFF, 32'h80000000, 32'h0,        1'b1, 32'h0},        // R5
        '{4'd9,  2'd2, 16'h0000, 32'h80000000, 32'd4,        32'hF8000000, 1'b1, 32'h0},        // R6
        '{4'd9,  2'd2, 16'h0000, 32'h80000000, 32'd32,       32'hFFFFFFFF, 1'b1, 32'h0},        // R6
        '{4'd9,  2'd2, 16'h0000, 32'h7FFFFFFF, 32'h80000000, 32'h0,        1'b1, 32'h0},        // R6
        '{4'd10, 2'd2, 16'h0000, 32'h64,       32'h32,       32'h32,       1'b1, 32'h0},        // R7
        '{4'd10, 2'd2, 16'h0000, 32'h32,       32'h64,       32'h32,       1'b1, 32'h0},        // R7
        '{4'd10, 2'd2, 16'h0000, 32'hFFFFFFFF, 32'h1,        32'h1,        1'b1, 32'h0},        // R7
        '{4'd11, 2'd2, 16'h0000, 32'h0,        32'hFFFFFFFB, 32'h5,        1'b1, 32'h0},        // R8
        '{4'd11, 2'd2, 16'h0000, 32'h0,        32'h80000000, 32'h80000000, 1'b1, 32'h0},        // R8
        '{4'd13, 2'd2, 16'h0000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1,        1'b1, 32'hFFFFFFFE}, // R9
        '{4'd12, 2'd2, 16'h0000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1,        1'b1, 32'h0},        // R9
        '{4'd12, 2'd2, 16'h0000, 32'hFFFFFFFE, 32'h3,        32'hFFFFFFFA, 1'b1, 32'hFFFFFFFF}, // R9
        '{4'd13, 2'd2, 16'h0000, 32'hFFFFFFFE, 32'h3,        32'hFFFFFFFA, 1'b1, 32'h2},        // R9
        '{4'd13, 2'd0, 16'h0000, 32'h00010001, 32'h00010001, 32'h1,        1'b1, 32'h1},        // R10
        '{4'd14, 2'd2, 16'h0011, 32'h5,        32'h5,        32'h0,        1'b0, 32'h0},        // R4
        '{4'd0,  2'd1, 16'h0011, 32'h0000FFFF, 32'h0,        32'h0,        1'b1, 32'h0},        // R10
        '{4'd3,  2'd0, 16'h0000, 32'h0,        32'h1,        32'hFF,       1'b1, 32'h0}         // R10
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0:            return "R1";
            4'd1, 4'd2:      return "R2";
            4'd3, 4'd4:      return "R3";
            4'd5:            return "R4";
            4'd7, 4'd8:      return "R5";
            4'd9:            return "R6";
            4'd10:           return "R7";
            4'd6, 4'd11:     return "R8";
            4'd12, 4'd13:    return "R9";
            default:         return "R4";
        endcase
    endfunction

    // Behavioural reference, written from the requirements.
    task automatic ref_calc(input logic [3:0] op, input logic [1:0] sz, input logic [15:0] fl,
                            input logic [31:0] a, input logic [31:0] b,
                            output logic [31:0] res, output logic wb, output logic [31:0] hi);
        logic [31:0] y;
        logic [63:0] p;
        logic        ch;
        ch = fl[4] & fl[0];
        p  = '0;
        case (op)
            4'd0:  y = a + b + {31'b0, ch};
            4'd1:  y = a + b + {31'b0, fl[0]};
            4'd2:  y = a + b + {31'b0, fl[8]};
            4'd3, 4'd5: y = a - b - {31'b0, ch};
            4'd4:  y = 32'd0 - b - {31'b0, ch};
            4'd6:  y = b;
            4'd7:  y = (b > 31) ? 32'd0 : a << b[4:0];
            4'd8:  y = (b > 31) ? 32'd0 : a >> b[4:0];
            4'd9:  y = (b > 31) ? (a[31] ? 32'hFFFFFFFF : 32'd0) : 32'($signed(a) >>> b[4:0]);
            4'd10: y = (a > b) ? b : a;
            4'd11: y = ($signed(b) < 0) ? (32'd0 - b) : b;
            4'd12: begin p = 64'(longint'($signed(a)) * longint'($signed(b))); y = p[31:0]; end
            4'd13: begin p = {32'd0, a} * {32'd0, b}; y = p[31:0]; end
            default: y = 32'd0;
        endcase
        if (sz == 2'd0) y = y & 32'hFF;
        else if (sz == 2'd1) y = y & 32'hFFFF;
        res = y;
        wb  = (op <= 4'd13) && (op != 4'd5);
        hi  = p[63:32];
    endtask

    task automatic report(input bit ok, input string req, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [1:0] sz, input logic [15:0] fl,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] e_res, input logic e_wb, input logic [31:0] e_hi);
        logic mul;
        mul = (op == 4'd12) || (op == 4'd13);
        @(negedge clk);
        in_op = op; in_size = sz; in_flags = fl; in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (mul) begin
            report(busy && !out_valid, "R11", "mul first cycle busy,valid",
                   {126'd0, busy, out_valid}, {126'd0, 2'b10});
            @(negedge clk);
        end
        report(out_valid && out_result == e_res && out_wb == e_wb && out_hi == e_hi
               && out_hi_we == mul && !busy, req_of(op), "valid,res,wb,hi,hwe",
               {30'd0, out_valid, out_result, out_wb, out_hi, out_hi_we},
               {30'd0, 1'b1, e_res, e_wb, e_hi, mul});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] er, eh;
        logic        ew;

        // R12: reset state
        repeat (3) @(negedge clk);
        report(!out_valid && !out_wb && !out_hi_we && !busy && out_result == 0 && out_hi == 0,
               "R12", "reset outputs", {64'd0, out_result, out_hi}, 128'd0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++)
            run_op(TBL[i].op, TBL[i].sz, TBL[i].fl, TBL[i].a, TBL[i].b,
                   TBL[i].res, TBL[i].wb, TBL[i].hi);

        // Random sweep against the reference, all opcodes and flag mixes.
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  op;
            logic [1:0]  sz;
            logic [15:0] fl;
            logic [31:0] a, b;
            op = 4'($urandom_range(0, 15));
            sz = 2'($urandom_range(0, 3));
            fl = 16'($urandom);
            a  = $urandom;
            case ($urandom_range(0, 5))
                0: b = 32'd31;
                1: b = 32'd32;
                2: b = 32'h80000000;
                3: b = 32'($urandom_range(0, 40));
                default: b = $urandom;
            endcase
            ref_calc(op, sz, fl, a, b, er, ew, eh);
            run_op(op, sz, fl, a, b, er, ew, eh);
        end

        // R11: back-to-back single-cycle operations
        @(negedge clk);
        in_op = 4'd0; in_size = 2'd2; in_flags = 16'h0; in_a = 32'd1; in_b = 32'd2; in_valid = 1'b1;
        @(negedge clk);
        report(out_valid && out_result == 32'd3, "R11", "first of pair", {96'd0, out_result}, 128'd3);
        in_op = 4'd6; in_b = 32'hCAFE;
        @(negedge clk);
        in_valid = 1'b0;
        report(out_valid && out_result == 32'hCAFE, "R11", "second of pair", {96'd0, out_result}, 128'hCAFE);

        // R11: request during busy is ignored
        @(negedge clk);
        in_op = 4'd13; in_size = 2'd2; in_a = 32'd3; in_b = 32'd5; in_valid = 1'b1;
        @(negedge clk);
        in_op = 4'd0; in_a = 32'd1; in_b = 32'd1;  // held while busy
        report(busy && !out_valid, "R11", "busy while mul", {126'd0, busy, out_valid}, {126'd0, 2'b10});
        @(negedge clk);
        in_valid = 1'b0;
        report(out_valid && out_result == 32'd15 && out_hi_we, "R11", "mul result",
               {96'd0, out_result}, 128'd15);
        @(negedge clk);
        report(!out_valid, "R11", "ignored request left no result", {127'd0, out_valid}, 128'd0);

        // R12: reset while a multiply is pending
        @(negedge clk);
        in_op = 4'd12; in_a = 32'd7; in_b = 32'd7; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        report(!busy && !out_valid && !out_hi_we && out_hi == 0, "R12", "reset during busy",
               {126'd0, busy, out_valid}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        report(!out_valid, "R12", "no result after reset", {127'd0, out_valid}, 128'd0);

        finish_run();
    end
endmodule